// File: doc/BRIEF.md
# Expansion Interrupt Aggregator

The aggregator collects sixteen peripheral interrupt lines into one level interrupt for a host processor. Each line passes through a two-stage synchroniser. A rising edge on the synchronised level latches a pending bit, and that bit stays set until the host acknowledges it. A per-line enable vector decides which pending bits reach the host. The single output is high while any pending bit is also enabled.

The host reaches the block over a simple 16-bit register bus. The bus has no wait states: a write takes effect at the clock edge where the write strobe is high, and read data is combinational from the address. There are four registers. The pending view is acknowledged by writing ones. The live view shows the synchronised input levels. The enable vector is changed through one address that only sets bits and another that only clears bits, so any single line can be masked or acknowledged without a read-modify-write.

All ports are plain control and status signals, so the block has no valid/ready stream interface and applies no back-pressure.

Top module: `irqx_aggregator`

## Requirements
- R1: After reset the pending vector, the enable vector, the live view and irq_out are all zero, and every register reads zero.
- R2: Line n is sampled through two flip-flops. If irq_in[n] rises before clock edge k, pending bit n (bit n of offset 0x16) reads 1 after edge k+2. This happens whether or not line n is enabled.
- R3: A pending bit stays 1 after its input falls, until it is acknowledged.
- R4: Writing to offset 0x16 clears each pending bit written as 1. Bits written as 0 keep their value.
- R5: If a write to 0x16 acknowledges line n in the same cycle that a new synchronised rising edge on line n is detected, the pending bit stays 1.
- R6: Offset 0x18 reads the synchronised input levels. A change on irq_in becomes visible after two clock edges, not after one.
- R7: Writing to offset 0x1A sets each enable bit written as 1 and leaves the other enable bits unchanged. Reading 0x1A returns the enable vector.
- R8: Writing to offset 0x1C clears each enable bit written as 1 and leaves the other enable bits unchanged. Reading 0x1C returns the enable vector and has no side effect. After a write of 0xFFFF to 0x1C, irq_out is low from the next cycle.
- R9: irq_out is high exactly when some line is both pending and enabled. Enabling a line that is already pending raises irq_out right after the enabling write.
- R10: Reads of any other offset return zero, and writes to any other offset change no state.
- R11: Write 0xFFFF to 0x1C, then 0xFFFF to 0x16, while no new edge arrives. After this sequence no line is enabled, none is pending, and irq_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Peripheral interrupt levels, bit n is line n |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq_out | output | 1 | Active-high level interrupt to the host |

## Verification
The bench builds the block with its default configuration of sixteen lines, two synchroniser stages and an 8-bit offset. At that size every line can be swept one at a time through the full cycle: edge, latch, enable, acknowledge and disable. Every enable bit can also be walked through both the set address and the clear address. Multi-line patterns check partial acknowledges and partial masking. A cycle-exact collision between a new edge and an acknowledge checks that the set wins. A set of unmapped and odd offsets checks that stray accesses have no effect.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_PEND = 8'h16;
  localparam logic [ADDR_W-1:0] OFS_LIVE = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 8'h1A;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 8'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_LIVE,
    SEL_ENSET,
    SEL_ENCLR
  } reg_sel_e;
endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irqx_pending.sv
module irqx_pending #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic             ack_we,
  input  logic [WIDTH-1:0] ack_bits,
  output logic [WIDTH-1:0] pending
);
  logic [WIDTH-1:0] level_d;
  logic [WIDTH-1:0] rise;
  logic [WIDTH-1:0] clr_bits;

  assign rise     = level & ~level_d;
  assign clr_bits = ack_we ? ack_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_d <= '0;
      pending <= '0;
    end else begin
      level_d <= level;
      // a rising edge is applied after the clear, so it wins a collision
      pending <= (pending & ~clr_bits) | rise;
    end
  end

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending & $past(rise)) == $past(rise))); // R2
  AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_we |=> ((pending & $past(pending)) == $past(pending))); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((pending & $past(ack_bits & ~rise)) == '0)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && ((ack_bits & rise) != '0)) |=> ((pending & $past(ack_bits & rise)) == $past(ack_bits & rise))); // R5
endmodule

// File: rtl/irqx_enable.sv
module irqx_enable #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wbits,
  output logic [WIDTH-1:0] enable
);
  logic [WIDTH-1:0] set_bits;
  logic [WIDTH-1:0] clr_bits;

  assign set_bits = set_we ? wbits : '0;
  assign clr_bits = clr_we ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enable <= '0;
    else        enable <= (enable | set_bits) & ~clr_bits;
  end

  AST_SET_ONLY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> (enable == ($past(enable) | $past(wbits)))); // R7
  AST_CLR_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> (enable == ($past(enable) & ~$past(wbits)))); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(enable)); // R10
endmodule

// File: rtl/irqx_regif.sv
module irqx_regif
  import irqx_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W,
  parameter int unsigned AW    = ADDR_W
) (
  input  logic [AW-1:0]    addr,
  input  logic             wr,
  input  logic [WIDTH-1:0] pending,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] enable,
  output logic             ack_we,
  output logic             set_we,
  output logic             clr_we,
  output logic [WIDTH-1:0] rdata
);
  reg_sel_e sel;

  always_comb begin
    unique case (addr)
      AW'(OFS_PEND):  sel = SEL_PEND;
      AW'(OFS_LIVE):  sel = SEL_LIVE;
      AW'(OFS_ENSET): sel = SEL_ENSET;
      AW'(OFS_ENCLR): sel = SEL_ENCLR;
      default:        sel = SEL_NONE;
    endcase
  end

  assign ack_we = wr && (sel == SEL_PEND);
  assign set_we = wr && (sel == SEL_ENSET);
  assign clr_we = wr && (sel == SEL_ENCLR);

  always_comb begin
    unique case (sel)
      SEL_PEND:            rdata = pending;
      SEL_LIVE:            rdata = live;
      SEL_ENSET, SEL_ENCLR: rdata = enable;
      default:             rdata = '0;
    endcase
  end

  always_comb begin
    AST_ONE_STROBE: assert ($onehot0({ack_we, set_we, clr_we})); // R10
  end
endmodule

// File: rtl/irqx_aggregator.sv
module irqx_aggregator
  import irqx_pkg::*;
#(
  parameter int unsigned LINES       = DATA_W,
  parameter int unsigned AW          = ADDR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [LINES-1:0] bus_wdata,
  output logic [LINES-1:0] bus_rdata,
  output logic             irq_out
);
  logic [LINES-1:0] live;
  logic [LINES-1:0] pending;
  logic [LINES-1:0] enable;
  logic             ack_we;
  logic             set_we;
  logic             clr_we;

  irqx_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(live)
  );

  irqx_pending #(.WIDTH(LINES)) u_pending (
    .clk(clk), .rst_n(rst_n), .level(live), .ack_we(ack_we),
    .ack_bits(bus_wdata), .pending(pending)
  );

  irqx_enable #(.WIDTH(LINES)) u_enable (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
    .wbits(bus_wdata), .enable(enable)
  );

  irqx_regif #(.WIDTH(LINES), .AW(AW)) u_regif (
    .addr(bus_addr), .wr(bus_wr), .pending(pending), .live(live),
    .enable(enable), .ack_we(ack_we), .set_we(set_we), .clr_we(clr_we),
    .rdata(bus_rdata)
  );

  assign irq_out = |(pending & enable);

  AST_MASK_ALL_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (&bus_wdata)) |=> !irq_out); // R8
  AST_OUT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (enable != '0)); // R9
  AST_OUT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pending != '0)); // R9
endmodule

// File: tb/test_irqx_aggregator.sv
`timescale 1ns/1ps
module test_irqx_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  localparam logic [7:0] A_PEND = 8'h16, A_LIVE = 8'h18, A_SET = 8'h1A, A_CLR = 8'h1C;

  always #2.5 clk = ~clk;

  irqx_aggregator i_irqx_aggregator (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] acc;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_reg("R1 pend", A_PEND, 16'h0);
    expect_reg("R1 live", A_LIVE, 16'h0);
    expect_reg("R1 set", A_SET, 16'h0);
    expect_reg("R1 clr", A_CLR, 16'h0);
    check("R1 irq", {15'b0, irq_out}, 16'h0);

    // R10 unmapped offsets: writes ignored, reads zero
    foreach (acc[i]) begin end
    wr(8'h00, 16'hFFFF);
    wr(8'h17, 16'hFFFF);
    wr(8'h1B, 16'hFFFF);
    wr(8'h1E, 16'hFFFF);
    expect_reg("R10 enable untouched", A_SET, 16'h0);
    expect_reg("R10 read 0x00", 8'h00, 16'h0);
    expect_reg("R10 read 0x1B", 8'h1B, 16'h0);
    expect_reg("R10 read 0xFF", 8'hFF, 16'h0);

    // R7 R8 walk enable bits
    acc = '0;
    for (int n = 0; n < 16; n++) begin
      wr(A_SET, 16'(1) << n);
      acc |= 16'(1) << n;
      expect_reg("R7 set walk", A_SET, acc);
      expect_reg("R8 clr readback", A_CLR, acc);
    end
    wr(A_CLR, 16'hAAAA);
    expect_reg("R8 partial clear", A_SET, 16'h5555);
    wr(A_SET, 16'h0000);
    expect_reg("R7 zero write", A_SET, 16'h5555);
    for (int n = 0; n < 16; n += 2) begin
      wr(A_CLR, 16'(1) << n);
      acc = 16'h5555 & ~((16'(2) << n) - 16'd1);
      expect_reg("R8 clr walk", A_SET, acc);
    end

    // Per-line sweep: R2 R3 R4 R6 R9
    for (int n = 0; n < 16; n++) begin
      irq_in = 16'(1) << n;
      step(1);
      expect_reg("R6 lag", A_LIVE, 16'h0);
      step(1);
      expect_reg("R6 live", A_LIVE, 16'(1) << n);
      expect_reg("R2 not yet", A_PEND, 16'h0);
      step(1);
      expect_reg("R2 latched", A_PEND, 16'(1) << n);
      check("R9 masked low", {15'b0, irq_out}, 16'h0);
      irq_in = '0;
      step(3);
      expect_reg("R3 sticky", A_PEND, 16'(1) << n);
      expect_reg("R6 live low", A_LIVE, 16'h0);
      wr(A_SET, 16'(1) << n);
      check("R9 enable pending", {15'b0, irq_out}, 16'h1);
      wr(A_PEND, ~(16'(1) << n));
      expect_reg("R4 zeros kept", A_PEND, 16'(1) << n);
      wr(A_PEND, 16'(1) << n);
      expect_reg("R4 acked", A_PEND, 16'h0);
      check("R9 low after ack", {15'b0, irq_out}, 16'h0);
      wr(A_CLR, 16'(1) << n);
    end

    // R9 multi-line: lines 8, 10, 11
    irq_in = 16'h0D00;
    step(3);
    expect_reg("R2 multi", A_PEND, 16'h0D00);
    wr(A_SET, 16'h0400);
    check("R9 line10", {15'b0, irq_out}, 16'h1);
    wr(A_PEND, 16'h0400);
    expect_reg("R4 partial ack", A_PEND, 16'h0900);
    check("R9 none enabled pending", {15'b0, irq_out}, 16'h0);
    wr(A_SET, 16'h0100);
    check("R9 line8", {15'b0, irq_out}, 16'h1);
    wr(A_CLR, 16'h0100);
    check("R8 masked line8", {15'b0, irq_out}, 16'h0);
    irq_in = '0;
    wr(A_PEND, 16'h0900);
    wr(A_CLR, 16'hFFFF);

    // R5 collision on line 3
    irq_in = 16'h0008;
    step(3);
    irq_in = '0;
    step(3);
    expect_reg("R5 setup", A_PEND, 16'h0008);
    irq_in = 16'h0008;
    step(2);
    wr(A_PEND, 16'h0008);
    expect_reg("R5 set wins", A_PEND, 16'h0008);
    wr(A_PEND, 16'h0008);
    expect_reg("R5 later ack", A_PEND, 16'h0000);
    irq_in = '0;
    step(3);

    // R11 init sequence with everything pending and enabled
    irq_in = 16'hFFFF;
    step(3);
    wr(A_SET, 16'hFFFF);
    check("R11 pre irq", {15'b0, irq_out}, 16'h1);
    wr(A_CLR, 16'hFFFF);
    check("R8 mask all", {15'b0, irq_out}, 16'h0);
    wr(A_PEND, 16'hFFFF);
    expect_reg("R11 pend", A_PEND, 16'h0);
    expect_reg("R11 enable", A_SET, 16'h0);
    check("R11 irq", {15'b0, irq_out}, 16'h0);
    irq_in = '0;
    step(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule